// File: doc/BRIEF.md
# Debug and Fail-Safe Mode Controller

This block decides, for a power-management companion chip, whether the watchdog supervises the host or is bypassed for bench debugging. It also picks the fail-safe behaviour code that drives the safe output stage. A comparator outside the block reports whether the debug pin voltage sits inside its window. The block samples that flag once, on the strobe that marks the move from the init-reset state into the init state. If the flag is high at that moment, debug mode is latched and no watchdog refresh is needed.

Debug mode ends when the window flag drops or when the SPI exit command arrives, and the SPI command takes priority. After it ends, debug mode can be entered again only at the next init strobe. The safe-mode code follows a decoded hardware strap until an SPI write overrides it. While debug mode is active, the strap has no effect. A watchdog window elapsing without a refresh drives the active-low safe output low, and it stays low until reset.

Top module: `dbg_failsafe_ctrl`

## Requirements
- R1: After reset, dbg_active_o=0, wd_en_o=0, safe_no=1 and safe_code_o equals the SAFE_DEF parameter (default 0).
- R2: If dbg_win_i=1 at a clock edge where init_exit_i=1 and spi_dbg_exit_i=0, then dbg_active_o=1 after that edge. If dbg_win_i=0 there, dbg_active_o=0.
- R3: While dbg_active_o=1, wd_en_o=0, and a missing refresh never drives safe_no low.
- R4: If dbg_win_i=0 at an edge while in debug mode, debug mode is left at that edge, wd_en_o=1, and a full watchdog window without a refresh then drives safe_no low.
- R5: spi_dbg_exit_i=1 at an edge clears debug mode at that edge, even if dbg_win_i=1 and even if init_exit_i=1 at the same edge.
- R6: Once debug mode has been left, dbg_active_o stays 0 until the next edge with init_exit_i=1, whatever dbg_win_i does.
- R7: Let edge E be the first edge with wd_en_o=1, or an edge with wd_refresh_i=1. If no refresh follows, safe_no goes low at edge E+W, where W=wd_window_i (W at least 1). A refresh at least every W cycles keeps safe_no high.
- R8: Once safe_no=0, it stays 0 until rst_ni is asserted, whatever is refreshed or commanded.
- R9: With no SPI safe write since reset and debug mode inactive, safe_code_o equals the strap_code_i value present at the previous clock edge.
- R10: spi_safe_wr_i=1 at an edge loads spi_safe_code_i into safe_code_o after that edge. Later strap changes then have no effect until reset.
- R11: While dbg_active_o=1, changes on strap_code_i do not change safe_code_o.
- R12: Before the first init_exit_i strobe after reset, wd_en_o=0 and safe_no stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_exit_i | input | 1 | Strobe: init-reset to init transition |
| dbg_win_i | input | 1 | Debug pin voltage inside window |
| spi_dbg_exit_i | input | 1 | SPI command strobe: leave debug mode |
| strap_code_i | input | SAFE_W | Decoded hardware safe-mode strap |
| spi_safe_wr_i | input | 1 | SPI command strobe: write safe-mode code |
| spi_safe_code_i | input | SAFE_W | Safe-mode code carried by the SPI write |
| wd_refresh_i | input | 1 | Watchdog refresh strobe |
| wd_window_i | input | CNT_W | Watchdog window length in cycles |
| dbg_active_o | output | 1 | Debug mode status flag |
| wd_en_o | output | 1 | Watchdog enabled |
| safe_code_o | output | SAFE_W | Selected safe-mode code |
| safe_no | output | 1 | Safe output, active low, sticky |

## Verification
A corrupted debug latch shows one cycle later on dbg_active_o and wd_en_o together. It also shows a window later on safe_no, which falls either when it should not or not when it should. A wrong window counter moves the safe_no falling edge off the exact cycle E+W. The bench therefore checks that cycle for every small window length. A wrong source select or strap hold appears on safe_code_o one cycle after the strap or SPI stimulus, so sweeping every strap code covers every value.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  typedef enum logic {
    SRC_STRAP = 1'b0,
    SRC_SPI   = 1'b1
  } safe_src_e;
endpackage

// File: rtl/dfs_mode_trk.sv
module dfs_mode_trk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_exit_i,
  input  logic dbg_win_i,
  input  logic spi_dbg_exit_i,
  output logic dbg_o,
  output logic started_o
);
  logic dbg_q, started_q;
  logic dbg_d;

  // spi exit outranks both the pin and the init sample
  always_comb begin
    if (init_exit_i) dbg_d = dbg_win_i && !spi_dbg_exit_i;
    else             dbg_d = dbg_q && dbg_win_i && !spi_dbg_exit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_q     <= 1'b0;
      started_q <= 1'b0;
    end else begin
      dbg_q <= dbg_d;
      if (init_exit_i) started_q <= 1'b1;
    end
  end

  assign dbg_o     = dbg_q;
  assign started_o = started_q;
endmodule

// File: rtl/dfs_wdog.sv
module dfs_wdog #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             refresh_i,
  input  logic [CNT_W-1:0] window_i,
  output logic             fault_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             expire;
  logic             fault_q;

  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign expire  = en_i && !refresh_i && !fault_q && (cnt_inc >= {1'b0, window_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else begin
      if (!en_i || refresh_i) cnt_q <= '0;
      else if (!expire && !fault_q) cnt_q <= cnt_inc[CNT_W-1:0];
      if (expire) fault_q <= 1'b1;
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/dfs_safe_sel.sv
module dfs_safe_sel
  import dfs_pkg::*;
#(
  parameter int unsigned     SAFE_W   = 3,
  parameter logic [SAFE_W-1:0] SAFE_DEF = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_i,
  input  logic [SAFE_W-1:0] strap_i,
  input  logic              spi_wr_i,
  input  logic [SAFE_W-1:0] spi_code_i,
  output logic [SAFE_W-1:0] code_o
);
  safe_src_e         src_q;
  logic [SAFE_W-1:0] hw_q, spi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= SRC_STRAP;
      hw_q  <= SAFE_DEF;
      spi_q <= SAFE_DEF;
    end else begin
      if (!dbg_i) hw_q <= strap_i;
      if (spi_wr_i) begin
        src_q <= SRC_SPI;
        spi_q <= spi_code_i;
      end
    end
  end

  assign code_o = (src_q == SRC_SPI) ? spi_q : hw_q;
endmodule

// File: rtl/dbg_failsafe_ctrl.sv
module dbg_failsafe_ctrl #(
  parameter int unsigned       SAFE_W   = 3,
  parameter int unsigned       CNT_W    = 8,
  parameter logic [SAFE_W-1:0] SAFE_DEF = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_exit_i,
  input  logic              dbg_win_i,
  input  logic              spi_dbg_exit_i,
  input  logic [SAFE_W-1:0] strap_code_i,
  input  logic              spi_safe_wr_i,
  input  logic [SAFE_W-1:0] spi_safe_code_i,
  input  logic              wd_refresh_i,
  input  logic [CNT_W-1:0]  wd_window_i,
  output logic              dbg_active_o,
  output logic              wd_en_o,
  output logic [SAFE_W-1:0] safe_code_o,
  output logic              safe_no
);
  logic dbg, started, fault;

  dfs_mode_trk i_mode (
    .clk_i, .rst_ni, .init_exit_i, .dbg_win_i, .spi_dbg_exit_i,
    .dbg_o(dbg), .started_o(started)
  );

  assign wd_en_o      = started && !dbg;
  assign dbg_active_o = dbg;

  dfs_wdog #(.CNT_W(CNT_W)) i_wdog (
    .clk_i, .rst_ni, .en_i(wd_en_o), .refresh_i(wd_refresh_i),
    .window_i(wd_window_i), .fault_o(fault)
  );

  assign safe_no = !fault;

  dfs_safe_sel #(.SAFE_W(SAFE_W), .SAFE_DEF(SAFE_DEF)) i_sel (
    .clk_i, .rst_ni, .dbg_i(dbg), .strap_i(strap_code_i),
    .spi_wr_i(spi_safe_wr_i), .spi_code_i(spi_safe_code_i), .code_o(safe_code_o)
  );
endmodule

// File: rtl/dfs_checker.sv
module dfs_checker #(
  parameter int unsigned SAFE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_exit_i,
  input logic              dbg_win_i,
  input logic              spi_dbg_exit_i,
  input logic              spi_safe_wr_i,
  input logic [SAFE_W-1:0] spi_safe_code_i,
  input logic              dbg_active_o,
  input logic              wd_en_o,
  input logic [SAFE_W-1:0] safe_code_o,
  input logic              safe_no
);
  p_entry_at_init_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_active_o ##1 dbg_active_o |-> $past(init_exit_i) && $past(dbg_win_i));

  p_wd_off_in_dbg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_active_o |-> !wd_en_o);

  p_pin_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_active_o && !dbg_win_i && !init_exit_i |=> !dbg_active_o);

  p_spi_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_dbg_exit_i |=> !dbg_active_o);

  p_no_reentry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_active_o && !init_exit_i |=> !dbg_active_o);

  p_fault_needs_wd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    safe_no ##1 !safe_no |-> $past(wd_en_o));

  p_safe_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !safe_no |=> !safe_no);

  p_spi_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_safe_wr_i |=> safe_code_o == $past(spi_safe_code_i));

  p_strap_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_active_o && !spi_safe_wr_i |=> $stable(safe_code_o));
endmodule

bind dbg_failsafe_ctrl dfs_checker #(.SAFE_W(SAFE_W)) i_dfs_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .init_exit_i(init_exit_i), .dbg_win_i(dbg_win_i),
  .spi_dbg_exit_i(spi_dbg_exit_i), .spi_safe_wr_i(spi_safe_wr_i),
  .spi_safe_code_i(spi_safe_code_i), .dbg_active_o(dbg_active_o), .wd_en_o(wd_en_o),
  .safe_code_o(safe_code_o), .safe_no(safe_no)
);

// File: tb/test_dbg_failsafe_ctrl.sv
`timescale 1ns/1ps
module test_dbg_failsafe_ctrl;
  localparam int SW = 3;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_exit = 1'b0, dbg_win = 1'b0, spi_exit = 1'b0;
  logic [SW-1:0] strap = '0, spi_code = '0;
  logic spi_wr = 1'b0, refresh = 1'b0;
  logic [CW-1:0] window = 8'd4;
  logic dbg_o, wd_en, safe_n;
  logic [SW-1:0] code_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dbg_failsafe_ctrl #(.SAFE_W(SW), .CNT_W(CW)) i_dbg_failsafe_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .init_exit_i(init_exit), .dbg_win_i(dbg_win),
    .spi_dbg_exit_i(spi_exit), .strap_code_i(strap), .spi_safe_wr_i(spi_wr),
    .spi_safe_code_i(spi_code), .wd_refresh_i(refresh), .wd_window_i(window),
    .dbg_active_o(dbg_o), .wd_en_o(wd_en), .safe_code_o(code_o), .safe_no(safe_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; init_exit = 0; dbg_win = 0; spi_exit = 0; spi_wr = 0; refresh = 0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  // init strobe over one edge; returns at the negedge after it
  task automatic do_init(input logic win);
    dbg_win = win; init_exit = 1'b1;
    cyc(1);
    init_exit = 1'b0;
  endtask

  // watchdog became enabled or was refreshed at the last posedge
  task automatic expect_expiry(input int w, input string req);
    for (int i = 1; i < w; i++) begin
      cyc(1);
      chk(safe_n == 1'b1, req, safe_n, 1);
    end
    cyc(1);
    chk(safe_n == 1'b0, req, safe_n, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    strap = 3'd0;
    do_reset();
    chk(dbg_o == 0, "R1", dbg_o, 0);
    chk(wd_en == 0, "R1", wd_en, 0);
    chk(safe_n == 1, "R1", safe_n, 1);
    chk(code_o == 0, "R1", code_o, 0);

    // R12 watchdog idle before init
    window = 8'd2;
    cyc(10);
    chk(wd_en == 0, "R12", wd_en, 0);
    chk(safe_n == 1, "R12", safe_n, 1);

    // R7 expiry cycle for each window length
    for (int w = 1; w <= 6; w++) begin
      do_reset();
      window = CW'(w);
      do_init(1'b0);
      chk(dbg_o == 0, "R2", dbg_o, 0);
      chk(wd_en == 1, "R7", wd_en, 1);
      expect_expiry(w, "R7");
      // R8 sticky
      refresh = 1'b1; cyc(3); refresh = 1'b0; cyc(3);
      chk(safe_n == 0, "R8", safe_n, 0);
    end
    do_reset();
    chk(safe_n == 1, "R8", safe_n, 1);

    // R7 refresh keeps alive, then stop
    window = 8'd4;
    do_init(1'b0);
    for (int k = 0; k < 8; k++) begin
      cyc(3); refresh = 1'b1; cyc(1); refresh = 1'b0;
      chk(safe_n == 1, "R7", safe_n, 1);
    end
    expect_expiry(4, "R7");

    // R2/R3 debug entry, no refresh needed
    do_reset();
    window = 8'd3;
    do_init(1'b1);
    chk(dbg_o == 1, "R2", dbg_o, 1);
    chk(wd_en == 0, "R3", wd_en, 0);
    cyc(20);
    chk(safe_n == 1, "R3", safe_n, 1);
    // R4 pin drop exits
    dbg_win = 1'b0;
    cyc(1);
    chk(dbg_o == 0, "R4", dbg_o, 0);
    chk(wd_en == 1, "R4", wd_en, 1);
    dbg_win = 1'b1;
    expect_expiry(3, "R4");
    chk(dbg_o == 0, "R6", dbg_o, 0);

    // R5 SPI exit with window still high, R6 no re-entry
    do_reset();
    do_init(1'b1);
    chk(dbg_o == 1, "R2", dbg_o, 1);
    spi_exit = 1'b1; cyc(1); spi_exit = 1'b0;
    chk(dbg_o == 0, "R5", dbg_o, 0);
    chk(wd_en == 1, "R5", wd_en, 1);
    refresh = 1'b1;
    cyc(10);
    chk(dbg_o == 0, "R6", dbg_o, 0);
    do_init(1'b1);
    refresh = 1'b0;
    chk(dbg_o == 1, "R6", dbg_o, 1);
    // R5 SPI exit beats simultaneous init
    spi_exit = 1'b1; init_exit = 1'b1; cyc(1); spi_exit = 1'b0; init_exit = 1'b0;
    chk(dbg_o == 0, "R5", dbg_o, 0);

    // R9 strap sweep
    do_reset();
    for (int c = 0; c < (1 << SW); c++) begin
      strap = SW'(c);
      cyc(1);
      chk(code_o == SW'(c), "R9", code_o, c);
    end
    // R10 SPI override holds through strap sweep
    spi_code = 3'd5; spi_wr = 1'b1; cyc(1); spi_wr = 1'b0;
    chk(code_o == 3'd5, "R10", code_o, 5);
    for (int c = 0; c < (1 << SW); c++) begin
      strap = SW'(c);
      cyc(1);
      chk(code_o == 3'd5, "R10", code_o, 5);
    end

    // R11 strap ignored in debug
    do_reset();
    strap = 3'd2;
    cyc(1);
    do_init(1'b1);
    for (int c = 0; c < (1 << SW); c++) begin
      strap = SW'(c);
      cyc(1);
      chk(code_o == 3'd2, "R11", code_o, 2);
    end
    strap = 3'd6;
    dbg_win = 1'b0;
    cyc(2);
    chk(code_o == 3'd6, "R9", code_o, 6);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule